// File: doc/BRIEF.md
# UART FIFO-Level Interrupt Controller

This block turns the occupancy of a UART's transmit and receive FIFOs, together with a few control fields and event pulses, into four interrupt sources. The sources are receive, error, transmit and modem. It keeps them in a sticky source-pending register. A mask register filters them into a masked pending register, and one level-sensitive interrupt line is raised whenever any masked bit is pending. A separate output tells a receive DMA engine that there is nothing to fetch.

The receive and transmit trigger levels are 3-bit fields scaled by a multiplier that depends on the channel class, which is a build-time parameter. The receive field counts from one and the transmit field from zero. When the receive timeout is disabled, any stored byte raises a receive request. The block also reports, one cycle after the fact, when a receive request condition should cancel a running timeout. The FIFOs, the serial engine and the bus decode are outside the block. Software writes arrive as one-cycle strobes with a 4-bit data word.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the source-pending, mask and masked-pending outputs become 0, and `irq_o`, `rx_dma_busy_o` and `tmo_cancel_o` become low.
- R2: Source bits are receive = bit 0, error = bit 1, transmit = bit 2 and modem = bit 3. `pend_o` always equals `src_pend_o & ~mask_o`, and `irq_o` is high exactly when `pend_o` is nonzero. A `mask_wr_i` strobe loads `wdata_i` into the mask.
- R3: A `pend_wr_i` or `src_wr_i` strobe clears the source-pending bits set in `wdata_i`, which also clears them in the masked pending value. Bits not named in `wdata_i` are kept.
- R4: If a source's set condition holds in the same cycle as a clear write to that bit, the bit ends up set.
- R5: The transmit level is `tx_trig_i * M` and the receive level is `(rx_trig_i + 1) * M`. M is 32 for class 0, 8 for classes 1 and 4, 2 for classes 2 and 3, and 0 for any other class.
- R6: With `fifo_en_i` high, the transmit bit is set in any cycle where `tx_count_i` is at or below the transmit level. A `tx_byte_i` pulse sets it in either mode.
- R7: With `fifo_en_i` high, the receive bit is set when `rx_count_i` is at or above the receive level. It is also set when `rx_count_i` is nonzero and `rx_tmo_en_i` is low.
- R8: `tmo_cancel_o` is high in the cycle after a cycle in which either receive condition of R7 held with the FIFO enabled, and low otherwise.
- R9: With `fifo_en_i` low, the receive bit is set exactly when `rx_hold_valid_i` is high. The receive count and levels have no effect, and `tmo_cancel_o` stays low.
- R10: The error bit is set by an `rx_ovf_i` pulse, or by an `rx_read_i` pulse while `fifo_en_i` is high and `rx_count_i` is 0. A read with data present, or with the FIFO disabled, does not set it.
- R11: A `modem_evt_i` pulse sets the modem bit.
- R12: `rx_dma_busy_o` is high in the cycle after a cycle in which `rx_mode_i` equals 2 and `rx_count_i` is 0, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en_i | input | 1 | FIFO mode enable |
| rx_tmo_en_i | input | 1 | Receive timeout enable |
| rx_mode_i | input | 2 | Receive mode field; value 2 selects DMA |
| tx_trig_i | input | 3 | Transmit trigger field |
| rx_trig_i | input | 3 | Receive trigger field |
| tx_count_i | input | CNT_W | Transmit FIFO occupancy |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| rx_hold_valid_i | input | 1 | Non-FIFO holding register holds data |
| tx_byte_i | input | 1 | Pulse: a byte was handed to the transmitter |
| rx_read_i | input | 1 | Pulse: the receive buffer was read |
| rx_ovf_i | input | 1 | Pulse: receive overflow |
| modem_evt_i | input | 1 | Pulse: modem status event |
| src_wr_i | input | 1 | Write strobe: clear source-pending bits |
| pend_wr_i | input | 1 | Write strobe: clear masked-pending bits |
| mask_wr_i | input | 1 | Write strobe: load the mask |
| wdata_i | input | 4 | Write data for the three strobes |
| src_pend_o | output | 4 | Source-pending register |
| mask_o | output | 4 | Mask register |
| pend_o | output | 4 | Masked pending register |
| irq_o | output | 1 | Level interrupt line |
| rx_dma_busy_o | output | 1 | Receive DMA has nothing to fetch |
| tmo_cancel_o | output | 1 | Receive request seen; cancel the timeout |

## Verification
The hardest point to reach is a receive level that the count cannot reach. For class 0 with a receive field of 7 the level is 256, while an 8-bit count tops out at 255, so with the timeout enabled the level path must never fire. Only the nonzero-with-timeout-off path can raise the receive bit there. The bench drives that count of 255 directly with the timeout enabled and then disabled. It also sweeps both counts across every level boundary on three instances of different channel class at once, writing a clear to the bit under test every cycle. That way the sticky bit reads back the raw set condition of that cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int unsigned SRC_N    = 4;
    localparam int unsigned TRIG_W   = 3;
    localparam int unsigned MAX_MULT = 32;
    localparam logic [1:0]  RXMODE_DMA = 2'd2;

    // Bit order of the source vector: rxd = bit 0 ... modem = bit 3
    typedef struct packed {
        logic modem;
        logic txd;
        logic err;
        logic rxd;
    } src_t;

    function automatic int unsigned trig_mult(input int unsigned cls);
        case (cls)
            0:       return 32;
            1, 4:    return 8;
            2, 3:    return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_level.sv
module uart_irq_level
    import uart_irq_pkg::*;
#(
    parameter int unsigned CLASS = 0,
    parameter int unsigned BIAS  = 0,
    parameter int unsigned LVL_W = 10
) (
    input  logic [TRIG_W-1:0] field_i,
    output logic [LVL_W-1:0]  level_o
);
    localparam int unsigned MULT = trig_mult(CLASS);

    logic [LVL_W-1:0] biased;

    assign biased  = LVL_W'(field_i) + LVL_W'(BIAS);
    assign level_o = biased * LVL_W'(MULT);

endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src
    import uart_irq_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned LVL_W = 10
) (
    input  logic             fifo_en_i,
    input  logic             rx_tmo_en_i,
    input  logic [1:0]       rx_mode_i,
    input  logic [CNT_W-1:0] tx_count_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic             rx_hold_valid_i,
    input  logic             tx_byte_i,
    input  logic             rx_read_i,
    input  logic             rx_ovf_i,
    input  logic             modem_evt_i,
    output src_t             set_o,
    output logic             rx_hit_o,
    output logic             dma_idle_o
);
    localparam int unsigned CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

    logic [CMP_W-1:0] tx_c, rx_c, tx_l, rx_l;
    logic             rx_empty;
    logic             tx_low, rx_high, rx_any;

    assign tx_c = CMP_W'(tx_count_i);
    assign rx_c = CMP_W'(rx_count_i);
    assign tx_l = CMP_W'(tx_level_i);
    assign rx_l = CMP_W'(rx_level_i);

    assign rx_empty = (rx_count_i == '0);
    assign tx_low   = (tx_c <= tx_l);
    assign rx_high  = (rx_c >= rx_l);
    assign rx_any   = !rx_empty && !rx_tmo_en_i;

    always_comb begin
        set_o    = '0;
        rx_hit_o = 1'b0;
        if (fifo_en_i) begin
            set_o.txd = tx_low;
            rx_hit_o  = rx_high || rx_any;
            set_o.rxd = rx_hit_o;
        end else begin
            set_o.rxd = rx_hold_valid_i;
        end
        if (tx_byte_i)
            set_o.txd = 1'b1;
        set_o.err   = rx_ovf_i || (rx_read_i && fifo_en_i && rx_empty);
        set_o.modem = modem_evt_i;
    end

    assign dma_idle_o = (rx_mode_i == RXMODE_DMA) && rx_empty;

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  src_t             set_i,
    input  logic             clr_wr_i,
    input  logic             mask_wr_i,
    input  logic [SRC_N-1:0] wdata_i,
    input  logic             rx_hit_i,
    input  logic             dma_idle_i,
    output logic [SRC_N-1:0] src_o,
    output logic [SRC_N-1:0] mask_o,
    output logic [SRC_N-1:0] pend_o,
    output logic             irq_o,
    output logic             dma_busy_o,
    output logic             tmo_cancel_o
);
    logic [SRC_N-1:0] set_v, clr_v, src_q, src_d, mask_q, mask_d, pend_q, pend_d;
    logic             irq_q, dma_q, tmo_q;

    assign set_v  = set_i;
    assign clr_v  = clr_wr_i ? wdata_i : '0;
    assign mask_d = mask_wr_i ? wdata_i : mask_q;

    for (genvar b = 0; b < SRC_N; b++) begin : g_bit
        // a set condition outranks a clear write in the same cycle
        assign src_d[b]  = set_v[b] | (src_q[b] & ~clr_v[b]);
        assign pend_d[b] = src_d[b] & ~mask_d[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            mask_q <= '0;
            pend_q <= '0;
            irq_q  <= 1'b0;
            dma_q  <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            src_q  <= src_d;
            mask_q <= mask_d;
            pend_q <= pend_d;
            irq_q  <= |pend_d;
            dma_q  <= dma_idle_i;
            tmo_q  <= rx_hit_i;
        end
    end

    assign src_o        = src_q;
    assign mask_o       = mask_q;
    assign pend_o       = pend_q;
    assign irq_o        = irq_q;
    assign dma_busy_o   = dma_q;
    assign tmo_cancel_o = tmo_q;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int unsigned CHAN_CLASS = 0,
    parameter int unsigned CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en_i,
    input  logic              rx_tmo_en_i,
    input  logic [1:0]        rx_mode_i,
    input  logic [TRIG_W-1:0] tx_trig_i,
    input  logic [TRIG_W-1:0] rx_trig_i,
    input  logic [CNT_W-1:0]  tx_count_i,
    input  logic [CNT_W-1:0]  rx_count_i,
    input  logic              rx_hold_valid_i,
    input  logic              tx_byte_i,
    input  logic              rx_read_i,
    input  logic              rx_ovf_i,
    input  logic              modem_evt_i,
    input  logic              src_wr_i,
    input  logic              pend_wr_i,
    input  logic              mask_wr_i,
    input  logic [SRC_N-1:0]  wdata_i,
    output logic [SRC_N-1:0]  src_pend_o,
    output logic [SRC_N-1:0]  mask_o,
    output logic [SRC_N-1:0]  pend_o,
    output logic              irq_o,
    output logic              rx_dma_busy_o,
    output logic              tmo_cancel_o
);
    localparam int unsigned LVL_W = TRIG_W + 1 + $clog2(MAX_MULT + 1);

    logic [LVL_W-1:0] tx_level, rx_level;
    src_t             set_vec;
    logic             rx_hit, dma_idle;

    uart_irq_level #(.CLASS(CHAN_CLASS), .BIAS(0), .LVL_W(LVL_W)) u_tx_lvl (
        .field_i (tx_trig_i),
        .level_o (tx_level)
    );

    uart_irq_level #(.CLASS(CHAN_CLASS), .BIAS(1), .LVL_W(LVL_W)) u_rx_lvl (
        .field_i (rx_trig_i),
        .level_o (rx_level)
    );

    uart_irq_src #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_src (
        .fifo_en_i       (fifo_en_i),
        .rx_tmo_en_i     (rx_tmo_en_i),
        .rx_mode_i       (rx_mode_i),
        .tx_count_i      (tx_count_i),
        .rx_count_i      (rx_count_i),
        .tx_level_i      (tx_level),
        .rx_level_i      (rx_level),
        .rx_hold_valid_i (rx_hold_valid_i),
        .tx_byte_i       (tx_byte_i),
        .rx_read_i       (rx_read_i),
        .rx_ovf_i        (rx_ovf_i),
        .modem_evt_i     (modem_evt_i),
        .set_o           (set_vec),
        .rx_hit_o        (rx_hit),
        .dma_idle_o      (dma_idle)
    );

    uart_irq_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .set_i        (set_vec),
        .clr_wr_i     (src_wr_i || pend_wr_i),
        .mask_wr_i    (mask_wr_i),
        .wdata_i      (wdata_i),
        .rx_hit_i     (rx_hit),
        .dma_idle_i   (dma_idle),
        .src_o        (src_pend_o),
        .mask_o       (mask_o),
        .pend_o       (pend_o),
        .irq_o        (irq_o),
        .dma_busy_o   (rx_dma_busy_o),
        .tmo_cancel_o (tmo_cancel_o)
    );

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en_i,
    input logic             rx_tmo_en_i,
    input logic [1:0]       rx_mode_i,
    input logic [CNT_W-1:0] tx_count_i,
    input logic [CNT_W-1:0] rx_count_i,
    input logic             rx_hold_valid_i,
    input logic             tx_byte_i,
    input logic             rx_ovf_i,
    input logic             modem_evt_i,
    input logic             src_wr_i,
    input logic             pend_wr_i,
    input logic [3:0]       wdata_i,
    input logic [3:0]       src_pend_o,
    input logic [3:0]       mask_o,
    input logic [3:0]       pend_o,
    input logic             irq_o,
    input logic             rx_dma_busy_o,
    input logic             tmo_cancel_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (src_pend_o == 4'd0 && mask_o == 4'd0 && pend_o == 4'd0 && !irq_o));

    assert_pend_masked_R2: assert property (@(posedge clk) disable iff (rst)
        pend_o == (src_pend_o & ~mask_o));

    assert_irq_line_R2: assert property (@(posedge clk) disable iff (rst)
        irq_o == (pend_o != 4'd0));

    assert_clear_modem_R3: assert property (@(posedge clk) disable iff (rst)
        (src_wr_i && wdata_i[3] && !modem_evt_i) |=> !src_pend_o[3]);

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        ((src_wr_i || pend_wr_i) && wdata_i[2] && tx_byte_i) |=> src_pend_o[2]);

    assert_tx_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (fifo_en_i && tx_count_i == '0) |=> src_pend_o[2]);

    assert_rx_any_R7: assert property (@(posedge clk) disable iff (rst)
        (fifo_en_i && rx_count_i != '0 && !rx_tmo_en_i) |=> (src_pend_o[0] && tmo_cancel_o));

    assert_no_cancel_R8: assert property (@(posedge clk) disable iff (rst)
        !fifo_en_i |=> !tmo_cancel_o);

    assert_hold_rx_R9: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en_i && rx_hold_valid_i) |=> src_pend_o[0]);

    assert_overflow_err_R10: assert property (@(posedge clk) disable iff (rst)
        rx_ovf_i |=> src_pend_o[1]);

    assert_modem_set_R11: assert property (@(posedge clk) disable iff (rst)
        modem_evt_i |=> src_pend_o[3]);

    assert_dma_busy_R12: assert property (@(posedge clk) disable iff (rst)
        (rx_mode_i == 2'd2 && rx_count_i == '0) |=> rx_dma_busy_o);

    assert_dma_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (rx_mode_i != 2'd2) |=> !rx_dma_busy_o);

endmodule

bind uart_irq_ctrl uart_irq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .fifo_en_i       (fifo_en_i),
    .rx_tmo_en_i     (rx_tmo_en_i),
    .rx_mode_i       (rx_mode_i),
    .tx_count_i      (tx_count_i),
    .rx_count_i      (rx_count_i),
    .rx_hold_valid_i (rx_hold_valid_i),
    .tx_byte_i       (tx_byte_i),
    .rx_ovf_i        (rx_ovf_i),
    .modem_evt_i     (modem_evt_i),
    .src_wr_i        (src_wr_i),
    .pend_wr_i       (pend_wr_i),
    .wdata_i         (wdata_i),
    .src_pend_o      (src_pend_o),
    .mask_o          (mask_o),
    .pend_o          (pend_o),
    .irq_o           (irq_o),
    .rx_dma_busy_o   (rx_dma_busy_o),
    .tmo_cancel_o    (tmo_cancel_o)
);

// File: tb/tb_uart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_ctrl;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1;
    logic       fen = 0, tmo_en = 0, hold = 0;
    logic [1:0] rmode = 0;
    logic [2:0] ttrig = 0, rtrig = 0;
    logic [7:0] tcnt = 0, rcnt = 0;
    logic       txb = 0, rrd = 0, ovf = 0, mdm = 0, swr = 0, pwr = 0, mwr = 0;
    logic [3:0] wd = 0;

    logic [3:0] o_src [3];
    logic [3:0] o_mask[3];
    logic [3:0] o_pend[3];
    logic       o_irq [3];
    logic       o_dma [3];
    logic       o_tmo [3];

    int compared = 0, mismatched = 0;
    bit done = 0;
    string tag = "R1";

    // channel classes of the three instances: multipliers 32, 2, 0
    int cls[3] = '{0, 2, 6};

    int m_src[3], m_mask[3], m_tmo[3], m_dma;

    uart_irq_ctrl #(.CHAN_CLASS(0)) dut (
        .clk(clk), .rst(rst), .fifo_en_i(fen), .rx_tmo_en_i(tmo_en), .rx_mode_i(rmode),
        .tx_trig_i(ttrig), .rx_trig_i(rtrig), .tx_count_i(tcnt), .rx_count_i(rcnt),
        .rx_hold_valid_i(hold), .tx_byte_i(txb), .rx_read_i(rrd), .rx_ovf_i(ovf),
        .modem_evt_i(mdm), .src_wr_i(swr), .pend_wr_i(pwr), .mask_wr_i(mwr), .wdata_i(wd),
        .src_pend_o(o_src[0]), .mask_o(o_mask[0]), .pend_o(o_pend[0]), .irq_o(o_irq[0]),
        .rx_dma_busy_o(o_dma[0]), .tmo_cancel_o(o_tmo[0]));

    uart_irq_ctrl #(.CHAN_CLASS(2)) dut_c2 (
        .clk(clk), .rst(rst), .fifo_en_i(fen), .rx_tmo_en_i(tmo_en), .rx_mode_i(rmode),
        .tx_trig_i(ttrig), .rx_trig_i(rtrig), .tx_count_i(tcnt), .rx_count_i(rcnt),
        .rx_hold_valid_i(hold), .tx_byte_i(txb), .rx_read_i(rrd), .rx_ovf_i(ovf),
        .modem_evt_i(mdm), .src_wr_i(swr), .pend_wr_i(pwr), .mask_wr_i(mwr), .wdata_i(wd),
        .src_pend_o(o_src[1]), .mask_o(o_mask[1]), .pend_o(o_pend[1]), .irq_o(o_irq[1]),
        .rx_dma_busy_o(o_dma[1]), .tmo_cancel_o(o_tmo[1]));

    uart_irq_ctrl #(.CHAN_CLASS(6)) dut_c6 (
        .clk(clk), .rst(rst), .fifo_en_i(fen), .rx_tmo_en_i(tmo_en), .rx_mode_i(rmode),
        .tx_trig_i(ttrig), .rx_trig_i(rtrig), .tx_count_i(tcnt), .rx_count_i(rcnt),
        .rx_hold_valid_i(hold), .tx_byte_i(txb), .rx_read_i(rrd), .rx_ovf_i(ovf),
        .modem_evt_i(mdm), .src_wr_i(swr), .pend_wr_i(pwr), .mask_wr_i(mwr), .wdata_i(wd),
        .src_pend_o(o_src[2]), .mask_o(o_mask[2]), .pend_o(o_pend[2]), .irq_o(o_irq[2]),
        .rx_dma_busy_o(o_dma[2]), .tmo_cancel_o(o_tmo[2]));

    function automatic int mult_of(input int c);
        case (c)
            0:       return 32;
            1, 4:    return 8;
            2, 3:    return 2;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string what, input int k, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s inst%0d actual=%0h expected=%0h", tag, what, k, act, exp);
        end
    endtask

    // one clock: model next state from present inputs, then compare after the edge
    task automatic cycle();
        int n_src[3], n_mask[3], n_tmo[3];
        int n_dma;
        for (int k = 0; k < 3; k++) begin
            int txl, rxl, set, clr;
            txl = int'(ttrig) * mult_of(cls[k]);
            rxl = (int'(rtrig) + 1) * mult_of(cls[k]);
            set = 0;
            n_tmo[k] = 0;
            if (fen) begin
                if (int'(tcnt) <= txl) set |= 4;
                if (int'(rcnt) >= rxl || (rcnt != 0 && !tmo_en)) begin
                    set |= 1;
                    n_tmo[k] = 1;
                end
            end else if (hold) set |= 1;
            if (txb) set |= 4;
            if (ovf || (rrd && fen && rcnt == 0)) set |= 2;
            if (mdm) set |= 8;
            clr = (swr || pwr) ? int'(wd) : 0;
            n_src[k]  = ((m_src[k] & ~clr) | set) & 15;
            n_mask[k] = mwr ? int'(wd) : m_mask[k];
            if (rst) begin
                n_src[k] = 0; n_mask[k] = 0; n_tmo[k] = 0;
            end
        end
        n_dma = (!rst && rmode == 2'd2 && rcnt == 0) ? 1 : 0;
        @(posedge clk);
        #1;
        m_dma = n_dma;
        for (int k = 0; k < 3; k++) begin
            int ep;
            m_src[k] = n_src[k]; m_mask[k] = n_mask[k]; m_tmo[k] = n_tmo[k];
            ep = m_src[k] & ~m_mask[k] & 15;
            chk("src_pend", k, int'(o_src[k]), m_src[k]);
            chk("mask", k, int'(o_mask[k]), m_mask[k]);
            chk("pend", k, int'(o_pend[k]), ep);
            chk("irq", k, int'(o_irq[k]), (ep != 0) ? 1 : 0);
            chk("dma_busy", k, int'(o_dma[k]), m_dma);
            chk("tmo_cancel", k, int'(o_tmo[k]), m_tmo[k]);
        end
        txb = 0; rrd = 0; ovf = 0; mdm = 0; swr = 0; pwr = 0; mwr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) begin m_src[k] = 0; m_mask[k] = 0; m_tmo[k] = 0; end
        m_dma = 0;

        // R1: reset state, with sources active during reset
        tag = "R1";
        hold = 1; mdm = 1;
        repeat (3) begin mdm = 1; cycle(); end
        hold = 0; rst = 0;
        cycle();

        // R2: mask filtering and the interrupt line
        tag = "R2";
        mdm = 1; cycle();
        mwr = 1; wd = 4'b1000; cycle();
        ovf = 1; cycle();
        mwr = 1; wd = 4'b0000; cycle();

        // R3: clear writes through either register
        tag = "R3";
        pwr = 1; wd = 4'b0010; cycle();
        swr = 1; wd = 4'b1000; cycle();
        swr = 1; wd = 4'b1111; cycle();

        // R4: set wins over clear in the same cycle
        tag = "R4";
        swr = 1; wd = 4'b1111; txb = 1; ovf = 1; cycle();
        pwr = 1; wd = 4'b1111; mdm = 1; cycle();
        swr = 1; wd = 4'b1111; cycle();

        // R5 R6: transmit level sweep, bit cleared each cycle so it shows the condition
        fen = 1; tmo_en = 1; rtrig = 7; rcnt = 0;
        for (int t = 0; t < 3; t++) begin
            ttrig = (t == 0) ? 3'd1 : (t == 1) ? 3'd0 : 3'd7;
            for (int v = 0; v < 260; v += 3) begin
                tag = "R5,R6";
                tcnt = 8'(v); swr = 1; wd = 4'b0100; cycle();
            end
        end
        tcnt = 8'd255;
        swr = 1; wd = 4'b1111; cycle();

        // R7 R8: receive level sweep with timeout on, then off
        for (int t = 0; t < 2; t++) begin
            tmo_en = (t == 0);
            rtrig = 3'd0;
            for (int v = 0; v < 70; v++) begin
                tag = "R7,R8";
                rcnt = 8'(v); swr = 1; wd = 4'b0001; cycle();
            end
            rtrig = 3'd3;
            for (int v = 0; v < 140; v += 5) begin
                tag = "R7,R8";
                rcnt = 8'(v); swr = 1; wd = 4'b0001; cycle();
            end
        end

        // R5 R7: unreachable class-0 receive level (256) at the top count
        tag = "R5,R7";
        rtrig = 3'd7; rcnt = 8'd255; tmo_en = 1;
        swr = 1; wd = 4'b0001; cycle();
        swr = 1; wd = 4'b0001; cycle();
        tmo_en = 0;
        swr = 1; wd = 4'b0001; cycle();
        tmo_en = 1;
        swr = 1; wd = 4'b1111; cycle();

        // R9: FIFO off, holding register decides, count ignored
        tag = "R9";
        fen = 0; rcnt = 8'd200; rtrig = 0; tmo_en = 0; hold = 0;
        swr = 1; wd = 4'b1111; cycle();
        cycle();
        hold = 1; cycle();
        hold = 0; swr = 1; wd = 4'b0001; cycle();
        cycle();

        // R10: error on overflow and on underflow read only
        tag = "R10";
        rrd = 1; rcnt = 0; cycle();
        fen = 1; tmo_en = 1; rtrig = 7; ttrig = 0; tcnt = 8'd9;
        rrd = 1; rcnt = 8'd5; cycle();
        rrd = 1; rcnt = 0; cycle();
        swr = 1; wd = 4'b0010; cycle();
        ovf = 1; cycle();
        swr = 1; wd = 4'b1111; cycle();

        // R11: modem event
        tag = "R11";
        mdm = 1; cycle();
        cycle();

        // R12: DMA busy over all mode values, empty and not
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 2; c++) begin
                tag = "R12";
                rmode = 2'(m); rcnt = 8'(c); cycle();
            end
        end

        // R2: mixed random traffic, with a mid-run reset (R1)
        for (int i = 0; i < 6000; i++) begin
            tag = "R2";
            fen = 1'($urandom); tmo_en = 1'($urandom); rmode = 2'($urandom);
            ttrig = 3'($urandom); rtrig = 3'($urandom); hold = 1'($urandom);
            tcnt = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 20);
            rcnt = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 20);
            txb = ($urandom % 8 == 0); rrd = ($urandom % 6 == 0);
            ovf = ($urandom % 16 == 0); mdm = ($urandom % 12 == 0);
            swr = ($urandom % 5 == 0); pwr = ($urandom % 5 == 0);
            mwr = ($urandom % 7 == 0); wd = 4'($urandom);
            if (i == 3000) begin tag = "R1"; rst = 1; end
            cycle();
            rst = 0;
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule